// File: doc/BRIEF.md
# Edge Thinning and Two-Level Threshold Stage

This stage sits after a gradient operator in a streaming edge-detection path. Each beat carries one pixel: an unsigned gradient magnitude and a 2-bit quantised gradient direction. The stage keeps a running window of the last two rows plus three pixels in a shift-register store. The window yields the full 3x3 neighbourhood around a centre pixel. The centre survives thinning only if its magnitude is not beaten by either of the two neighbours that lie along its gradient direction. The surviving magnitude is then graded against two fixed levels, 50 and 130. The result is one 8-bit value, either 0 or 255, copied into every colour symbol of the output beat so that a display path can show it directly.

Frames are delimited by start and end flags on the input. The line width is a parameter. The frame height is not: it is whatever the end flag says. After the end flag the stage pushes blank padding through the store to drain the last row, and it accepts no input while it does so. The output handshake stalls the whole stage. The frame flags leave the stage aligned with the first and last output pixels.

Top module: `nms_edge_classifier`

## Requirements
- R1: Every input pixel of a frame produces exactly one output pixel, in input order, and nothing else is emitted.
- R2: The direction code selects the compared pair: 0 = left/right, 1 = upper-right/lower-left, 2 = above/below, 3 = upper-left/lower-right.
- R3: The centre passes the local-maximum test when its magnitude is greater than or equal to each selected neighbour, so equal magnitudes pass.
- R4: A selected neighbour outside the frame (first/last row, first/last column) never causes the test to fail.
- R5: A magnitude above 130 gives 255 whatever the local-maximum test says.
- R6: A magnitude from 50 to 130 inclusive gives 255 if it passed the local-maximum test, else 0.
- R7: A magnitude below 50 gives 0.
- R8: The edge value appears in all three 8-bit symbols of the output, bits 23:16, 15:8 and 7:0.
- R9: The output start flag is set only on the first pixel of a frame and the end flag only on its last.
- R10: While an output is valid and not accepted, the output stays valid and its value and flags do not change.
- R11: Once an end-flagged pixel has been accepted, no input is accepted until the last pixel of that frame is presented.
- R12: After reset, no output is valid and input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Stage takes the input pixel this cycle |
| inSop | input | 1 | First pixel of a frame |
| inEop | input | 1 | Last pixel of a frame |
| inMag | input | MAG_W | Gradient magnitude |
| inDir | input | 2 | Quantised gradient direction code |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Consumer takes the output pixel |
| outSop | output | 1 | First output pixel of a frame |
| outEop | output | 1 | Last output pixel of a frame |
| outRgb | output | NUM_SYM*SYM_W | Edge value in every colour symbol |

## Verification
The bench builds the stage with a line width of 6 and 8-bit magnitudes. The short line puts most pixels on or next to a frame border, so the first and last columns and rows come up again and again. One-row frames leave every vertical neighbour outside the frame. The 8-bit range lets the random magnitudes cluster around both threshold levels, so the values 49, 50, 130 and 131 all come up. A constant-magnitude frame exercises ties, and irregular valid and ready patterns cover stalls during the drain after each frame end.

// File: rtl/nmsPkg.sv
package nmsPkg;

  typedef enum logic [1:0] {
    DIR_HORZ = 2'd0,
    DIR_D45  = 2'd1,
    DIR_VERT = 2'd2,
    DIR_D135 = 2'd3
  } gradDir_t;

  typedef struct packed {
    logic advance;
    logic pad;
    logic edgeLeft;
    logic edgeRight;
    logic edgeTop;
  } nmsStrobe_t;

endpackage

// File: rtl/nms_ctrl.sv
module nms_ctrl
  import nmsPkg::*;
#(
  parameter int LINE_W = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inSop,
  input  logic       inEop,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output nmsStrobe_t strb
);

  localparam int PCNT_W = $clog2(LINE_W + 3);
  localparam int COL_W  = $clog2(LINE_W);
  localparam int FL_W   = $clog2(LINE_W + 2);
  localparam logic [PCNT_W-1:0] CTR_PUSH = PCNT_W'(LINE_W + 2);
  localparam logic [COL_W-1:0]  LAST_COL = COL_W'(LINE_W - 1);

  logic              ctrValid;
  logic              flushing;
  logic              firstRow;
  logic [PCNT_W-1:0] pushCnt;
  logic [PCNT_W-1:0] newPush;
  logic [COL_W-1:0]  colCnt;
  logic [FL_W-1:0]   flushLeft;
  logic              slotFree;
  logic              accept;
  logic              advance;

  assign slotFree = !ctrValid || outReady;
  assign accept   = inValid && slotFree && !flushing;
  assign advance  = accept || (flushing && slotFree);

  always_comb begin
    if (accept && inSop)        newPush = PCNT_W'(1);
    else if (pushCnt == CTR_PUSH) newPush = pushCnt;
    else                         newPush = pushCnt + PCNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrValid  <= 1'b0;
      flushing  <= 1'b0;
      flushLeft <= '0;
      pushCnt   <= '0;
      colCnt    <= '0;
      firstRow  <= 1'b0;
    end else begin
      if (advance) begin
        pushCnt  <= newPush;
        ctrValid <= (newPush == CTR_PUSH);
        if (newPush == CTR_PUSH) begin
          if (pushCnt != CTR_PUSH) begin
            colCnt   <= '0;
            firstRow <= 1'b1;
          end else if (colCnt == LAST_COL) begin
            colCnt   <= '0;
            firstRow <= 1'b0;
          end else begin
            colCnt <= colCnt + COL_W'(1);
          end
        end
      end else if (outReady) begin
        ctrValid <= 1'b0;
      end

      if (accept && inEop) begin
        flushing  <= 1'b1;
        flushLeft <= FL_W'(LINE_W + 1);
      end else if (flushing && slotFree) begin
        flushLeft <= flushLeft - FL_W'(1);
        if (flushLeft == FL_W'(1)) flushing <= 1'b0;
      end
    end
  end

  assign inReady        = slotFree && !flushing;
  assign outValid       = ctrValid;
  assign strb.advance   = advance;
  assign strb.pad       = flushing;
  assign strb.edgeLeft  = (colCnt == '0);
  assign strb.edgeRight = (colCnt == LAST_COL);
  assign strb.edgeTop   = firstRow;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid); // R10
  AST_EOP_BLOCK: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && inEop |=> !inReady); // R11

endmodule

// File: rtl/nms_datapath.sv
module nms_datapath
  import nmsPkg::*;
#(
  parameter int LINE_W  = 64,
  parameter int MAG_W   = 11,
  parameter int LO_TH   = 50,
  parameter int HI_TH   = 130,
  parameter int SYM_W   = 8,
  parameter int NUM_SYM = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  nmsStrobe_t               strb,
  input  logic                     ctrValid,
  input  logic [MAG_W-1:0]         inMag,
  input  logic [1:0]               inDir,
  input  logic                     inSop,
  input  logic                     inEop,
  output logic                     outSop,
  output logic                     outEop,
  output logic [NUM_SYM*SYM_W-1:0] outRgb
);

  localparam int DEPTH = 2 * LINE_W + 3;
  localparam int I_BR  = 0;
  localparam int I_B   = 1;
  localparam int I_BL  = 2;
  localparam int I_R   = LINE_W;
  localparam int I_C   = LINE_W + 1;
  localparam int I_L   = LINE_W + 2;
  localparam int I_TR  = 2 * LINE_W;
  localparam int I_T   = 2 * LINE_W + 1;
  localparam int I_TL  = 2 * LINE_W + 2;
  localparam logic [MAG_W-1:0] LO_V = MAG_W'(LO_TH);
  localparam logic [MAG_W-1:0] HI_V = MAG_W'(HI_TH);

  logic [MAG_W-1:0] magQ [DEPTH];
  logic [1:0]       dirQ [I_C+1];
  logic [I_C:0]     sopQ;
  logic [I_C:0]     eopQ;
  logic [I_BL:0]    liveQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) magQ[k] <= '0;
      for (int k = 0; k <= I_C; k++) dirQ[k] <= '0;
      sopQ  <= '0;
      eopQ  <= '0;
      liveQ <= '0;
    end else if (strb.advance) begin
      magQ[0]  <= strb.pad ? '0 : inMag;
      dirQ[0]  <= strb.pad ? '0 : inDir;
      sopQ[0]  <= !strb.pad && inSop;
      eopQ[0]  <= !strb.pad && inEop;
      liveQ[0] <= !strb.pad;
      for (int k = 1; k < DEPTH; k++) magQ[k] <= magQ[k-1];
      for (int k = 1; k <= I_C; k++) dirQ[k] <= dirQ[k-1];
      sopQ[I_C:1]  <= sopQ[I_C-1:0];
      eopQ[I_C:1]  <= eopQ[I_C-1:0];
      liveQ[I_BL:1] <= liveQ[I_BL-1:0];
    end
  end

  logic [MAG_W-1:0] magC, nbA, nbB;
  logic             outA, outB, isMax;
  logic [SYM_W-1:0] edgeVal;

  assign magC = magQ[I_C];

  always_comb begin
    nbA  = magQ[I_L];
    nbB  = magQ[I_R];
    outA = strb.edgeLeft;
    outB = strb.edgeRight;
    case (gradDir_t'(dirQ[I_C]))
      DIR_HORZ: begin
        nbA = magQ[I_L];  outA = strb.edgeLeft;
        nbB = magQ[I_R];  outB = strb.edgeRight;
      end
      DIR_D45: begin
        nbA = magQ[I_TR]; outA = strb.edgeTop || strb.edgeRight;
        nbB = magQ[I_BL]; outB = !liveQ[I_BL] || strb.edgeLeft;
      end
      DIR_VERT: begin
        nbA = magQ[I_T];  outA = strb.edgeTop;
        nbB = magQ[I_B];  outB = !liveQ[I_B];
      end
      DIR_D135: begin
        nbA = magQ[I_TL]; outA = strb.edgeTop || strb.edgeLeft;
        nbB = magQ[I_BR]; outB = !liveQ[I_BR] || strb.edgeRight;
      end
      default: ;
    endcase
    isMax = (outA || magC >= nbA) && (outB || magC >= nbB);

    if (magC > HI_V)       edgeVal = '1;
    else if (magC >= LO_V) edgeVal = isMax ? '1 : '0;
    else                   edgeVal = '0;
  end

  for (genvar s = 0; s < NUM_SYM; s++) begin : g_sym
    assign outRgb[s*SYM_W +: SYM_W] = edgeVal;
  end

  assign outSop = sopQ[I_C];
  assign outEop = eopQ[I_C];

  AST_STRONG_SET: assert property (@(posedge clk) disable iff (rst)
    ctrValid && magC > HI_V |-> outRgb[SYM_W-1:0] == '1); // R5
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ctrValid && magC < LO_V |-> outRgb[SYM_W-1:0] == '0); // R7

endmodule

// File: rtl/nms_edge_classifier.sv
module nms_edge_classifier
  import nmsPkg::*;
#(
  parameter int LINE_W  = 64,
  parameter int MAG_W   = 11,
  parameter int LO_TH   = 50,
  parameter int HI_TH   = 130,
  parameter int SYM_W   = 8,
  parameter int NUM_SYM = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic                     inSop,
  input  logic                     inEop,
  input  logic [MAG_W-1:0]         inMag,
  input  logic [1:0]               inDir,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     outSop,
  output logic                     outEop,
  output logic [NUM_SYM*SYM_W-1:0] outRgb
);

  nmsStrobe_t strb;

  nms_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inSop    (inSop),
    .inEop    (inEop),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  nms_datapath #(
    .LINE_W (LINE_W), .MAG_W (MAG_W), .LO_TH (LO_TH), .HI_TH (HI_TH),
    .SYM_W  (SYM_W),  .NUM_SYM (NUM_SYM)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .ctrValid (outValid),
    .inMag    (inMag),
    .inDir    (inDir),
    .inSop    (inSop),
    .inEop    (inEop),
    .outSop   (outSop),
    .outEop   (outEop),
    .outRgb   (outRgb)
  );

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> $stable(outRgb) && $stable(outSop) && $stable(outEop)); // R10
  AST_SYM_MATCH: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outRgb[SYM_W-1:0] == '0 || outRgb[SYM_W-1:0] == '1); // R8

endmodule

// File: tb/sim_nms_edge_classifier.sv
module sim_nms_edge_classifier;

  localparam int LW = 6, MW = 8, LO = 50, HI = 130, MAXP = 1024;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, inValid, inReady, inSop, inEop, outValid, outReady, outSop, outEop;
  logic [MW-1:0] inMag;
  logic [1:0]    inDir;
  logic [23:0]   outRgb;

  nms_edge_classifier #(.LINE_W(LW), .MAG_W(MW), .LO_TH(LO), .HI_TH(HI)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inSop(inSop),
    .inEop(inEop), .inMag(inMag), .inDir(inDir), .outValid(outValid),
    .outReady(outReady), .outSop(outSop), .outEop(outEop), .outRgb(outRgb));

  int errors = 0, checks = 0;
  logic [MW-1:0] pMag [MAXP];
  logic [1:0]    pDir [MAXP];
  bit            pSop [MAXP];
  bit            pEop [MAXP];
  logic [7:0]    pExp [MAXP];
  string         pTag [MAXP];
  int            nPix = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] genMag(int mode);
    int sel;
    if (mode == 1) return MW'(90);
    if (mode != 3) return MW'(LO + $urandom % (HI - LO + 1));
    sel = $urandom % 4;
    case (sel)
      0: return MW'(LO - 3 + $urandom % 7);
      1: return MW'(HI - 3 + $urandom % 7);
      2: return MW'($urandom % 256);
      default: return MW'(LO + $urandom % (HI - LO + 1));
    endcase
  endfunction

  function automatic bit nbPass(int base, int h, int r, int c, int dr, int dc);
    int rr, cc;
    rr = r + dr;
    cc = c + dc;
    if (rr < 0 || rr >= h || cc < 0 || cc >= LW) return 1'b1;
    return pMag[base + r*LW + c] >= pMag[base + rr*LW + cc];
  endfunction

  task automatic addFrame(int h, int mode, string tag);
    int base, idx, dr, dc;
    bit pass;
    base = nPix;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < LW; c++) begin
        idx = base + r*LW + c;
        pMag[idx] = genMag(mode);
        pDir[idx] = 2'($urandom % 4);
        pSop[idx] = (r == 0 && c == 0);
        pEop[idx] = (r == h-1 && c == LW-1);
      end
    for (int r = 0; r < h; r++)
      for (int c = 0; c < LW; c++) begin
        idx = base + r*LW + c;
        // R2: 0 left/right, 1 upper-right/lower-left, 2 above/below, 3 upper-left/lower-right
        case (pDir[idx])
          2'd0: begin dr = 0;  dc = -1; end
          2'd1: begin dr = -1; dc = 1;  end
          2'd2: begin dr = -1; dc = 0;  end
          default: begin dr = -1; dc = -1; end
        endcase
        pass = nbPass(base, h, r, c, dr, dc) && nbPass(base, h, r, c, -dr, -dc);
        if (pMag[idx] > HI)       begin pExp[idx] = 8'hFF; pTag[idx] = "R5"; end
        else if (pMag[idx] >= LO) begin pExp[idx] = pass ? 8'hFF : 8'h00; pTag[idx] = tag; end
        else                      begin pExp[idx] = 8'h00; pTag[idx] = "R7"; end
      end
    nPix += LW * h;
  endtask

  initial begin
    int inIdx, outIdx, cyc;
    bit afterEop, held, timedOut;
    logic [23:0] hRgb;
    bit hSop, hEop;
    void'($urandom(32'd7321));
    inIdx = 0; outIdx = 0; cyc = 0;
    afterEop = 0; held = 0; timedOut = 0;
    hRgb = '0; hSop = 0; hEop = 0;

    addFrame(4, 0, "R2");   // weak magnitudes, all directions
    addFrame(3, 1, "R3");   // equal magnitudes: ties must pass
    addFrame(1, 2, "R4");   // one row: vertical neighbours outside
    for (int f = 0; f < 20; f++) addFrame(1 + $urandom % 5, 3, "R6");

    rst = 1'b1; inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    inMag = '0; inDir = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(outValid == 1'b0, "R12", "outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R12", "inReady after reset", inReady, 1);

    while (outIdx < nPix) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin timedOut = 1; break; end
      if (inIdx < nPix) begin
        inValid = ($urandom % 4) != 0;
        inMag = pMag[inIdx]; inDir = pDir[inIdx];
        inSop = pSop[inIdx]; inEop = pEop[inIdx];
      end else begin
        inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
      end
      outReady = (cyc % 200 < 100) ? (($urandom % 2) == 0) : (($urandom % 8) != 0);
      #1;
      if (held)
        chk(outValid && outRgb == hRgb && outSop == hSop && outEop == hEop,
            "R10", "stalled output changed", outRgb, hRgb);
      held = outValid && !outReady;
      hRgb = outRgb; hSop = outSop; hEop = outEop;
      if (afterEop && !(outValid && outEop))
        chk(!inReady, "R11", "inReady during drain", inReady, 0);
      if (outValid && outReady) begin
        if (outIdx < nPix) begin
          chk(outRgb[7:0] == pExp[outIdx], pTag[outIdx], $sformatf("pixel %0d", outIdx),
              outRgb[7:0], pExp[outIdx]);
          chk(outRgb[23:16] == outRgb[7:0] && outRgb[15:8] == outRgb[7:0], "R8",
              "symbol replication", outRgb, {3{pExp[outIdx]}});
          chk(outSop == pSop[outIdx] && outEop == pEop[outIdx], "R9",
              $sformatf("flags pixel %0d", outIdx), {outSop, outEop},
              {pSop[outIdx], pEop[outIdx]});
        end
        if (outEop) afterEop = 0;
        outIdx++;
      end
      if (inValid && inReady) begin
        if (pEop[inIdx]) afterEop = 1;
        inIdx++;
      end
    end

    if (timedOut) chk(1'b0, "R1", "watchdog expired", cyc, 0);
    chk(outIdx == nPix, "R1", "output count", outIdx, nPix);
    inValid = 1'b0;
    outReady = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk(!outValid, "R1", "extra output after last frame", outValid, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule